// File: doc/BRIEF.md
# MDIO Management Master

This block runs read and write transactions on a two-wire PHY management bus. It produces the management clock itself by dividing its reference clock, and it drives and samples one bidirectional data line. An external tri-state pad holds the line. The block supplies the output value and a drive-enable for that pad, and it reads the pad's input value. A host asks for a transaction by raising a start request together with a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The host keeps start high until the block raises done.

After reset, and after every frame, the block sends a preamble of 32 ones. If no request is waiting when the preamble ends, the block parks in an idle state with the line high. A request that arrives while the block is idle starts the frame on the next bit boundary, with no new preamble. A request that arrives during the preamble starts the frame as soon as the preamble ends.

On a read, the PHY must pull the line low in the second turnaround bit. If it does not, the block drops the frame at once, keeps the old read data, and raises an error so that the host can retry.

Top module: `mdio_master`

## Requirements
- R1: While reset (asynchronous, active low) is applied, the outputs are mdc=0, mdio_out=1, mdio_oe=1, done=0, err=0 and rd_data=0.
- R2: The management clock has a period of 2*HALF_DIV reference cycles, with HALF_DIV cycles high and HALF_DIV cycles low. With the default of 10 and a 50 MHz reference clock, this gives 2.5 MHz.
- R3: After reset, and while no request is waiting, the line is driven (mdio_oe=1) at level 1, and no 0 bit appears on it.
- R4: A frame is 32 bits, sent most significant bit first, in this order: start 01, opcode (01 for write, 10 for read), PHY address (5 bits), register address (5 bits), turnaround, data (16 bits). In a write frame the turnaround is 10 and every bit is driven. The output bits change only on a falling edge of mdc.
- R5: host_rnw=1 selects a read and host_rnw=0 selects a write. In a read, mdio_oe is 0 for the two turnaround bits and the 16 data bits. The data bits are sampled on the rising edges of mdc. They appear on rd_data when done rises, and rd_data changes at no other time.
- R6: In a read, if mdio_in is 1 at the rising edge of mdc in the second turnaround bit, the frame ends there. done and err rise, rd_data keeps its old value, and the line returns to driven 1s.
- R7: done stays 1 for as long as start is held. It falls within 3 reference cycles after start is deasserted. While done is 1, or while start is low, no new frame starts.
- R8: Every frame is followed by a preamble of 32 driven ones. A request that is waiting when the preamble ends starts its frame straight after the preamble, so the run of ones after a read is exactly 32.
- R9: When a new transaction is accepted, err returns to 0.
- R10: A write frame leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Transaction request, held until done |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_phy | input | 5 | PHY address |
| host_reg | input | 5 | Register address |
| host_wdata | input | 16 | Write data |
| mdio_in | input | 1 | Data line value read from the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value driven to the pad |
| mdio_oe | output | 1 | Pad drive enable (1 = master drives) |
| done | output | 1 | Transaction complete |
| err | output | 1 | Read aborted in turnaround |
| rd_data | output | 16 | Last successful read data |

## Verification
Bits on the line are due HALF_DIV reference cycles after each falling edge of mdc. The bench therefore samples the line and mdio_oe 1 ns after each rising edge of mdc, where the value is stable. The bench changes the PHY response straight after a rising edge, so the value is settled before the next rise samples it. done, err and rd_data change on the falling edge that follows the last bit, which is up to HALF_DIV cycles after the last rise. The bench polls for that falling edge at the reference clock's falling edges and allows a bounded margin. The clearing of done goes through the two-flop synchronizer plus one register, so the bench checks it four reference cycles after start is dropped.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_start,
  input  logic        host_rnw,
  input  logic [4:0]  host_phy,
  input  logic [4:0]  host_reg,
  input  logic [15:0] host_wdata,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data
);
  localparam int DW = $clog2(2 * HALF_DIV);
  localparam logic [DW-1:0] RISE_AT = DW'(HALF_DIV - 1);
  localparam logic [DW-1:0] FALL_AT = DW'(2 * HALF_DIV - 1);

  typedef enum logic [1:0] {S_PRE, S_IDLE, S_FRAME} st_t;

  st_t          st;
  logic [DW-1:0] div;
  logic [4:0]   bitcnt;
  logic [31:0]  shreg;
  logic [15:0]  rxsh;
  logic         rnw_q, ta_bad, sync1, start_s;

  wire tick_rise = (div == RISE_AT);
  wire tick_fall = (div == FALL_AT);
  wire req       = start_s && !done;
  wire in_frame  = (st == S_FRAME);

  assign mdio_out = in_frame ? shreg[31] : 1'b1;
  assign mdio_oe  = !(in_frame && rnw_q && (bitcnt >= 5'd14));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, start_s} <= 2'b00;
    else        {sync1, start_s} <= {host_start, sync1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE;  div <= '0;  mdc <= 1'b0;  bitcnt <= '0;
      shreg <= '0;  rxsh <= '0; rnw_q <= 1'b0; ta_bad <= 1'b0;
      done <= 1'b0; err <= 1'b0; rd_data <= '0;
    end else begin
      div <= tick_fall ? '0 : div + 1'b1;
      if (tick_rise) mdc <= 1'b1;
      if (tick_fall) mdc <= 1'b0;
      if (!start_s) done <= 1'b0;

      if (tick_rise && in_frame) begin
        if (bitcnt == 5'd15) ta_bad <= mdio_in;
        if (bitcnt[4])       rxsh   <= {rxsh[14:0], mdio_in};
      end

      if (tick_fall) begin
        case (st)
          S_PRE, S_IDLE: begin
            if (st == S_PRE && bitcnt != 5'd31) bitcnt <= bitcnt + 1'b1;
            else if (req) begin
              st     <= S_FRAME;
              bitcnt <= '0;
              rnw_q  <= host_rnw;
              err    <= 1'b0;
              shreg  <= {2'b01, host_rnw ? 2'b10 : 2'b01, host_phy, host_reg,
                         host_rnw ? 18'h3FFFF : {2'b10, host_wdata}};
            end else begin
              st     <= S_IDLE;
              bitcnt <= '0;
            end
          end
          default: begin
            if (bitcnt == 5'd15 && rnw_q && ta_bad) begin
              st <= S_PRE; bitcnt <= '0; err <= 1'b1; done <= 1'b1;
            end else if (bitcnt == 5'd31) begin
              st <= S_PRE; bitcnt <= '0; done <= 1'b1;
              if (rnw_q) rd_data <= rxsh;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= {shreg[30:0], 1'b0};
            end
          end
        endcase
      end
    end
  end

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start_s) |=> done); // R7
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_s && !in_frame) |=> !done); // R7
  AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != $past(rd_data)) |-> ($rose(done) && !err)); // R5
  AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (rnw_q && $rose(done))); // R6
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> $fell(mdc)); // R4
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc)); // R5
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_start = 1'b0, host_rnw = 1'b0, mdio_in = 1'b1;
  logic [4:0] host_phy = '0, host_reg = '0;
  logic [15:0] host_wdata = '0;
  logic mdc, mdio_out, mdio_oe, done, err;
  logic [15:0] rd_data;
  int checks = 0, fails = 0;
  int run = 0, last_run = 0, zero_seen = 0;
  logic [15:0] exp_rd = '0;

  always #10 clk = ~clk;

  mdio_master u0 (.clk, .rst_n, .host_start, .host_rnw, .host_phy, .host_reg,
    .host_wdata, .mdio_in, .mdc, .mdio_out, .mdio_oe, .done, .err, .rd_data);

  always @(posedge mdc) begin
    if (mdio_oe && mdio_out) run <= run + 1;
    else begin last_run <= run; run <= 0; end
    if (mdio_oe && !mdio_out) zero_seen <= zero_seen + 1;
  end

  // {rnw, ta_bad, phy[4:0], reg[4:0], data[15:0]}
  localparam logic [27:0] VEC [0:5] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 1'b0, 5'h10, 5'h0A, 16'hFFFF},
    {1'b1, 1'b1, 5'h03, 5'h02, 16'hDEAD},
    {1'b1, 1'b0, 5'h00, 5'h11, 16'h1234},
    {1'b0, 1'b0, 5'h00, 5'h00, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [27:0] v, input logic prev_read, input logic drop);
    logic rnw, bad;
    logic [31:0] exp, got;
    logic oe_ok;
    int last;
    rnw = v[27]; bad = v[26];
    exp = {2'b01, rnw ? 2'b10 : 2'b01, v[25:21], v[20:16], 2'b10, v[15:0]};
    host_rnw = rnw; host_phy = v[25:21]; host_reg = v[20:16]; host_wdata = v[15:0];
    host_start = 1'b1;
    got = '1; oe_ok = 1'b1;
    forever begin
      @(posedge mdc); #1;
      if (mdio_oe && !mdio_out) break;
    end
    got[31] = 1'b0;
    chk(prev_read ? "R8 preamble exact" : "R8 preamble min",
        prev_read ? last_run : 32'(last_run >= 32), prev_read ? 32 : 1);
    last = (rnw && bad) ? 15 : 31;
    for (int i = 1; i <= last; i++) begin
      mdio_in = (i == 15) ? bad : (i >= 16 ? v[31 - i] : 1'b1);
      @(posedge mdc); #1;
      got[31 - i] = mdio_out;
      if (mdio_oe !== !(rnw && i >= 14)) oe_ok = 1'b0;
    end
    mdio_in = 1'b1;
    if (rnw) chk("R4 R5 read header", {18'h0, got[31:18]}, {18'h0, exp[31:18]});
    else     chk("R4 write frame", got, exp);
    chk("R5 drive enable", {31'h0, oe_ok}, 1);
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    if (rnw && !bad) exp_rd = v[15:0];
    chk("R7 done raised", {31'h0, done}, 1);
    chk(bad ? "R6 err set" : "R9 err clear", {31'h0, err}, {31'h0, bad});
    chk(rnw ? (bad ? "R6 rd kept" : "R5 rd data") : "R10 rd kept", {16'h0, rd_data}, {16'h0, exp_rd});
    @(negedge clk);
    chk("R6 line high after frame", {30'h0, mdio_oe, mdio_out}, 3);
    if (drop) begin
      host_start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 done cleared", {31'h0, done}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint t0, t1, t2;
    int z;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {11'h0, mdc, mdio_out, mdio_oe, done, err, rd_data}, {11'h0, 5'b01100, 16'h0});
    rst_n = 1'b1;
    repeat (40) @(posedge mdc);
    #1;
    chk("R3 idle line", {zero_seen, 2'b00} | {30'h0, mdio_oe, mdio_out}, 3);
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    chk("R2 mdc period", 32'(t2 - t0), 400);
    chk("R2 mdc high", 32'(t1 - t0), 200);

    for (int n = 0; n < 6; n++)
      txn(VEC[n], (n > 0) ? VEC[n-1][27] : 1'b0, 1'b1);

    txn({1'b0, 1'b0, 5'h15, 5'h07, 16'h0F0F}, 1'b0, 1'b0);
    z = zero_seen;
    repeat (2000) @(negedge clk);
    chk("R7 done held", {31'h0, done}, 1);
    chk("R7 no refire", 32'(zero_seen), 32'(z));
    host_start = 1'b0;
    repeat (2000) @(negedge clk);
    chk("R7 no start when low", 32'(zero_seen), 32'(z));
    chk("R3 idle after", {29'h0, done, mdio_oe, mdio_out}, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule